// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor

This block is a minimal processor whose instruction set has exactly one operation, so instructions carry no opcode. Each instruction is four consecutive memory words, read as four operand addresses: a first source, a second source, a destination and a branch target. The processor reads the two source words, subtracts the first from the second, and stores the difference at the destination. A negative difference sends control to the branch target. Any other result moves on to the next four-word instruction.

Program and data share one internal single-port word memory. While the core is held in reset, a load port writes that memory word by word. Whenever the core is not sequencing, the same address input reads the memory back. A start pulse begins execution at address zero. A taken branch whose target is the instruction's own address stops the core and raises a halt flag. Each instruction runs as a fixed eight-step sequence with one memory access per step: four field fetches, two operand reads, one result write and one program-counter update.

Top module: `subbr_core`

## Requirements
- R1: While reset is held, `busy` and `halted` are 0 and `pc` is 0.
- R2: A `start` pulse while idle after reset makes `busy` 1 on the next clock edge, with execution beginning at `pc` = 0. The instruction at `pc` occupies words `pc`, `pc+1`, `pc+2` and `pc+3`, holding the first source, second source, destination and branch target in that order.
- R3: Each instruction writes (second source word minus first source word), modulo 2^16, to the destination address.
- R4: When bit 15 of the difference is 1, the next `pc` is the branch target field.
- R5: When bit 15 of the difference is 0, including a zero difference and a wrapped subtraction, the next `pc` is `pc + 4` (modulo the memory size). This holds even when the target equals `pc`.
- R6: Every instruction takes exactly 8 clock cycles, so a run of n instructions ends with `halted` rising 8·n cycles after the edge that accepts `start`.
- R7: A taken branch whose target equals the current `pc` sets `halted`, clears `busy`, and leaves `pc` and memory unchanged afterwards. The destination write of that instruction still takes place.
- R8: `loadEn` writes memory only while `rst_n` is 0. When `rst_n` is 1, during a run or after a halt, it has no effect.
- R9: `start` has no effect while the core is halted.
- R10: Only the low 8 bits (ADDR_W) of each address field word are used as an address. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also enables preload |
| start | input | 1 | Begin execution from address 0 when idle |
| loadEn | input | 1 | Preload write strobe (effective only in reset) |
| loadAddr | input | 8 | Preload write / readback address |
| loadData | input | 16 | Preload write data |
| peekData | output | 16 | Memory word at loadAddr while not busy, else 0 |
| busy | output | 1 | Core is sequencing instructions |
| halted | output | 1 | Core stopped on a taken self-branch |
| pc | output | 8 | Current instruction address |

## Verification
The hardest situation to reach is a run that mixes taken and untaken branches with both forward and backward targets and still terminates. Only that kind of run shows that the target selection and the eight-cycle rhythm stay consistent over many instructions. The random programs use only forward targets, so every run is guaranteed to end in a closing self-branch. A directed countdown loop adds backward branches, and directed cases cover a zero difference, a wrapped difference with a clear sign bit, an untaken self-target and an immediate halt. Load strobes are injected in the middle of a run and after a halt, and a memory readback afterwards shows they left no trace.

// File: rtl/subbr_pkg.sv
package subbr_pkg;

  // sequencer steps of one instruction, plus idle and stopped
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_FETCH_D,
    ST_READ_A,
    ST_READ_B,
    ST_WRITE_C,
    ST_NEXT,
    ST_HALT
  } seqState_t;

  // memory address source chosen by the sequencer
  typedef enum logic [2:0] {
    AS_FIELD0,
    AS_FIELD1,
    AS_FIELD2,
    AS_FIELD3,
    AS_OPA,
    AS_OPB,
    AS_OPC
  } addrSel_t;

  localparam int unsigned NUM_FIELDS = 4;

  typedef struct packed {
    addrSel_t                addrSel;
    logic [NUM_FIELDS-1:0]   fieldLd;
    logic                    ldValA;
    logic                    ldValB;
    logic                    memWr;
    logic                    pcUpdate;
  } ctrlStrobe_t;

endpackage

// File: rtl/subbr_mem.sv
module subbr_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/subbr_ctrl.sv
module subbr_ctrl
  import subbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        diffNeg,
  input  logic        selfTarget,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        halted
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE:    if (start) nextState = ST_FETCH_A;
      ST_FETCH_A: begin
        strobe.addrSel = AS_FIELD0;
        strobe.fieldLd = NUM_FIELDS'(1) << 0;
        nextState      = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        strobe.addrSel = AS_FIELD1;
        strobe.fieldLd = NUM_FIELDS'(1) << 1;
        nextState      = ST_FETCH_C;
      end
      ST_FETCH_C: begin
        strobe.addrSel = AS_FIELD2;
        strobe.fieldLd = NUM_FIELDS'(1) << 2;
        nextState      = ST_FETCH_D;
      end
      ST_FETCH_D: begin
        strobe.addrSel = AS_FIELD3;
        strobe.fieldLd = NUM_FIELDS'(1) << 3;
        nextState      = ST_READ_A;
      end
      ST_READ_A: begin
        strobe.addrSel = AS_OPA;
        strobe.ldValA  = 1'b1;
        nextState      = ST_READ_B;
      end
      ST_READ_B: begin
        strobe.addrSel = AS_OPB;
        strobe.ldValB  = 1'b1;
        nextState      = ST_WRITE_C;
      end
      ST_WRITE_C: begin
        strobe.addrSel = AS_OPC;
        strobe.memWr   = 1'b1;
        nextState      = ST_NEXT;
      end
      ST_NEXT: begin
        if (diffNeg && selfTarget) begin
          nextState = ST_HALT;
        end else begin
          strobe.pcUpdate = 1'b1;
          nextState       = ST_FETCH_A;
        end
      end
      ST_HALT:    nextState = ST_HALT;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE) && (state != ST_HALT);
  assign halted = (state == ST_HALT);
endmodule

// File: rtl/subbr_dpath.sv
module subbr_dpath
  import subbr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              diffNeg,
  output logic              selfTarget,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(NUM_FIELDS);
  localparam int unsigned F_A = 0;
  localparam int unsigned F_B = 1;
  localparam int unsigned F_C = 2;
  localparam int unsigned F_D = 3;

  logic [ADDR_W-1:0] fieldReg [NUM_FIELDS];
  logic [DATA_W-1:0] valA, valB, diff;

  // one address register per instruction field; upper word bits dropped
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)                fieldReg[g] <= '0;
      else if (strobe.fieldLd[g]) fieldReg[g] <= memRdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valA <= '0;
      valB <= '0;
    end else begin
      if (strobe.ldValA) valA <= memRdata;
      if (strobe.ldValB) valB <= memRdata;
    end
  end

  assign diff     = valB - valA;
  assign memWdata = diff;
  assign diffNeg  = diff[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)               pc <= '0;
    else if (strobe.pcUpdate) pc <= diffNeg ? fieldReg[F_D] : pc + PC_STEP;
  end

  assign selfTarget = (fieldReg[F_D] == pc);

  always_comb begin
    unique case (strobe.addrSel)
      AS_FIELD0: memAddr = pc;
      AS_FIELD1: memAddr = pc + ADDR_W'(1);
      AS_FIELD2: memAddr = pc + ADDR_W'(2);
      AS_FIELD3: memAddr = pc + ADDR_W'(3);
      AS_OPA:    memAddr = fieldReg[F_A];
      AS_OPB:    memAddr = fieldReg[F_B];
      AS_OPC:    memAddr = fieldReg[F_C];
      default:   memAddr = pc;
    endcase
  end
endmodule

// File: rtl/subbr_core.sv
module subbr_core
  import subbr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] peekData,
  output logic              busy,
  output logic              halted,
  output logic [ADDR_W-1:0] pc
);
  ctrlStrobe_t       strobe;
  logic              diffNeg, selfTarget;
  logic [ADDR_W-1:0] coreAddr, memAddr;
  logic [DATA_W-1:0] coreWdata, memWdata, memRdata;
  logic              memWe;

  subbr_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .diffNeg    (diffNeg),
    .selfTarget (selfTarget),
    .strobe     (strobe),
    .busy       (busy),
    .halted     (halted)
  );

  subbr_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .memRdata   (memRdata),
    .memAddr    (coreAddr),
    .memWdata   (coreWdata),
    .diffNeg    (diffNeg),
    .selfTarget (selfTarget),
    .pc         (pc)
  );

  // core owns the port while sequencing; preload owns it only in reset
  assign memAddr  = busy ? coreAddr  : loadAddr;
  assign memWdata = busy ? coreWdata : loadData;
  assign memWe    = busy ? strobe.memWr : (!rst_n && loadEn);
  assign peekData = busy ? '0 : memRdata;

  subbr_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .clk   (clk),
    .we    (memWe),
    .addr  (memAddr),
    .wdata (memWdata),
    .rdata (memRdata)
  );
endmodule

// File: rtl/subbr_chk.sv
module subbr_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              halted,
  input logic              memWe,
  input logic [ADDR_W-1:0] pc
);
  // R7
  busy_halt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && halted));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  // R8
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> busy);

  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (pc == '0));

  // R4
  pc_moves_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> $past(busy));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !busy);
endmodule

bind subbr_core subbr_chk #(.ADDR_W(ADDR_W)) i_subbr_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .halted (halted),
  .memWe  (memWe),
  .pc     (pc)
);

// File: tb/test_subbr_core.sv
`timescale 1ns/1ps
module test_subbr_core;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic [DW-1:0] peekData;
  logic          busy, halted;
  logic [AW-1:0] pc;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] img [DEPTH];
  logic [DW-1:0] mdl [DEPTH];

  always #2 clk = ~clk;

  subbr_core i_subbr_core (
    .clk(clk), .rst_n(rst_n), .start(start), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .peekData(peekData),
    .busy(busy), .halted(halted), .pc(pc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd16();
    logic [31:0] r;
    r = $urandom();
    return r[DW-1:0];
  endfunction

  // field word: random upper bits above the address (R10)
  function automatic logic [DW-1:0] fld(input int addr);
    logic [DW-1:0] r;
    r = rnd16();
    return {r[DW-1:AW], addr[AW-1:0]};
  endfunction

  task automatic put_instr(input int at, input int a, input int b, input int c, input int d);
    img[at]   = fld(a);
    img[at+1] = fld(b);
    img[at+2] = fld(c);
    img[at+3] = fld(d);
  endtask

  task automatic fill_random();
    for (int i = 0; i < DEPTH; i++) img[i] = rnd16();
  endtask

  // reference: count executed instructions and the final pc
  task automatic run_model(output int steps, output logic [AW-1:0] endPc);
    logic [AW-1:0] p, a, b, c, d;
    logic [DW-1:0] diff;
    p = '0;
    steps = 0;
    for (int k = 0; k < 4000; k++) begin
      a = mdl[p][AW-1:0];
      b = mdl[p + AW'(1)][AW-1:0];
      c = mdl[p + AW'(2)][AW-1:0];
      d = mdl[p + AW'(3)][AW-1:0];
      diff = mdl[b] - mdl[a];
      mdl[c] = diff;
      steps++;
      if (diff[DW-1]) begin
        if (d == p) break;
        p = d;
      end else begin
        p = p + AW'(4);
      end
    end
    endPc = p;
  endtask

  task automatic run_case(input string name);
    int steps, cycles;
    logic [AW-1:0] expPc, keepPc;
    logic [DW-1:0] keepWord;
    for (int i = 0; i < DEPTH; i++) mdl[i] = img[i];
    run_model(steps, expPc);

    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = AW'(i); loadData = img[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(halted == 1'b0, "R1 halted in reset", halted, 0);
    chk(pc == '0, "R1 pc in reset", pc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(pc == '0, "R2 pc after start", pc, 0);
    while (!halted && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      // R8: load strobe outside reset during the run
      if (cycles == 3) begin
        loadEn = 1'b1; loadAddr = AW'(70); loadData = ~mdl[70];
        start = 1'b1; // ignored while busy
      end else begin
        loadEn = 1'b0; start = 1'b0;
      end
    end
    loadEn = 1'b0; start = 1'b0;
    chk(halted == 1'b1, {"R7 halted ", name}, halted, 1);
    chk(busy == 1'b0, "R7 busy cleared", busy, 0);
    chk(cycles == 8 * steps, {"R6 cycle count ", name}, cycles, 8 * steps);
    chk(pc == expPc, {"R4 R5 final pc ", name}, pc, expPc);
    // R3 R8 R10: full memory image compare
    for (int i = 0; i < DEPTH; i++) begin
      loadAddr = AW'(i);
      #0.5;
      chk(peekData == mdl[i], {"R3 memory word ", name}, peekData, mdl[i]);
    end
    // R9: start while halted
    keepPc = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(halted == 1'b1 && busy == 1'b0, "R9 start ignored when halted", busy, 0);
    chk(pc == keepPc, "R9 pc kept after start", pc, keepPc);
    // R8: load after halt has no effect
    keepWord = mdl[80];
    loadEn = 1'b1; loadAddr = AW'(80); loadData = ~keepWord;
    @(negedge clk);
    loadEn = 1'b0;
    #0.5;
    chk(peekData == keepWord, "R8 load ignored after halt", peekData, keepWord);
  endtask

  initial begin
    int k, hp;
    logic [31:0] r;
    void'($urandom(32'd20240611));

    // directed: zero diff with self target untaken (R5), wrapped diff (R5), then halt
    fill_random();
    img[64] = 16'h0005; img[65] = 16'h0005;
    img[67] = 16'h0001; img[68] = 16'h8000;
    img[200] = 16'h0001; img[201] = 16'h0000;
    put_instr(0, 64, 65, 66, 0);
    put_instr(4, 67, 68, 69, 4);
    put_instr(8, 200, 201, 202, 8);
    run_case("R5 zero and wrap");

    // directed: immediate halt at instruction 0 (R7)
    fill_random();
    img[200] = 16'h0001; img[201] = 16'h0000;
    put_instr(0, 200, 201, 90, 0);
    run_case("R7 halt first");

    // directed: countdown loop with backward branch (R4)
    fill_random();
    img[100] = 16'd3; img[101] = 16'd1; img[102] = 16'd0;
    put_instr(0, 101, 100, 100, 8);
    put_instr(4, 101, 102, 103, 0);
    put_instr(8, 101, 102, 104, 8);
    run_case("R4 backward loop");

    // random forward-only programs
    for (int t = 0; t < 12; t++) begin
      fill_random();
      r = $urandom(); k = 1 + int'(r % 6);
      for (int i = 0; i < k; i++) begin
        int a, b, c, d;
        r = $urandom(); a = 64 + int'(r % 128);
        r = $urandom(); b = 64 + int'(r % 128);
        r = $urandom(); c = 64 + int'(r % 128);
        r = $urandom(); d = 4 * (i + 1 + int'(r % (k - i)));
        put_instr(4 * i, a, b, c, d);
      end
      hp = 4 * k;
      img[200] = 16'h0001; img[201] = 16'h0000;
      put_instr(hp, 200, 201, 202, hp);
      run_case("R3 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule